// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

This block sits beside the time counters of a real-time clock and shifts the hour when a daylight-saving boundary is reached. It holds two programmable rules. The forward rule moves the clock one hour ahead and the reverse rule moves it one hour back. Each rule names a BCD month and a BCD hour. It also names a day, in one of two ways: a week of the month together with a weekday, or a BCD day-of-month. The week code 7 stands for the last week of the month. This lets a rule land on the final Sunday whether the month holds four or five of them.

The clock supplies its BCD month, date, hour, minute and second, the weekday, the length of the current month and a strobe that marks each new second. When the strobe arrives with minutes and seconds both at zero, the block takes a snapshot of the time and checks both rules against it. On a match it drives a one-cycle hour load with the adjusted BCD hour. A status flag records that summer time is in force. That flag arms the reverse rule and blocks the forward rule, so neither change repeats within its hour.

The controller has four states. IDLE waits for the hourly strobe and moves to CHECK. CHECK compares the snapshot with both rules. It moves to FWD on a forward match while the flag is clear, to REV on a reverse match while the flag is set, and otherwise back to IDLE. FWD and REV each last one cycle, drive the load and return to IDLE.

Top module: `dst_adjuster`

## Requirements
- R1: Writes to address BASE_ADDR+0..+7 (default 15h..1Ch) store, in this order: forward month, forward week/day, forward date, forward hour, reverse month, reverse week/day, reverse date, reverse hour. A write to any other address changes nothing.
- R2: Rules are evaluated only on a cycle where sec_tick is 1 and both cur_min and cur_sec are 00h. A strobe at any other minute or second produces no hour load.
- R3: In a week/day register, bit 6 = 1 selects week/day matching. Bits 5:3 give the week, where week n (1 to 5) covers dates 7n-6 to 7n. Bits 2:0 give the weekday, with 0 = Sunday. The rule matches only when both the week and the weekday agree.
- R4: Week code 7 matches when the weekday agrees and the date plus 7 is greater than cur_mdays, the BCD length of the month.
- R5: With bit 6 of the week/day register at 0, the rule matches when the date register equals cur_date.
- R6: The month (bits 4:0 of the month register) and the hour (BCD, 24-hour) must both equal the snapshot. Bit 7 of the forward-month register enables both rules. With it at 0, no hour load occurs.
- R7: A forward match while dst_active is 0 drives hour_load high for exactly one cycle, with hour_value = BCD hour + 1 (for example 09h becomes 10h), and sets dst_active.
- R8: A reverse match while dst_active is 1 drives one load, with hour_value = BCD hour - 1 (for example 10h becomes 09h), and clears dst_active. A reverse match while dst_active is 0 does nothing.
- R9: dst_active is 0 after reset. It clears in the cycle after a write of bit 7 = 0 to the forward-month register.
- R10: hour_load is high in the second clock cycle after the strobe cycle, and dst_active changes one cycle after that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| sec_tick | input | 1 | One-cycle strobe, time inputs hold the new second |
| cur_month | input | 8 | BCD month 01h-12h |
| cur_date | input | 8 | BCD day of month |
| cur_wday | input | 3 | Weekday, 0 = Sunday |
| cur_hour | input | 8 | BCD hour, 24-hour form |
| cur_min | input | 8 | BCD minutes |
| cur_sec | input | 8 | BCD seconds |
| cur_mdays | input | 8 | BCD number of days in current month |
| hour_load | output | 1 | One-cycle load of hour_value into the hour counter |
| hour_value | output | 8 | Adjusted BCD hour |
| dst_active | output | 1 | Forward change in effect |

## Verification
On every cycle, the assertions check the following: the load lasts one cycle; the flag rises only after a FWD cycle and falls only after a REV cycle or a disable write; FWD is never entered with the flag set; CHECK follows only an hourly strobe; and a write to the forward-month register updates the enable. Only the bench scenarios can show that the rules decode correctly. These cover first-week and second-week matching, last-week matching in 31-day and 30-day months, date matching, BCD carry and borrow in the hour value, and whether the flag blocks or permits each change.

// File: rtl/dst_pkg.sv
package dst_pkg;

    localparam int unsigned NUM_RULE_REGS = 4;
    localparam int unsigned NUM_RULES     = 2;
    localparam int unsigned DAYS_PER_WEEK = 7;
    localparam int unsigned MAX_WEEKS     = 5;
    localparam logic [2:0]  LAST_WEEK     = 3'd7;

    typedef struct packed {
        logic [7:0] month;   // bit 7 enable (forward rule only), 4:0 BCD month
        logic [7:0] wkday;   // bit 6 select, 5:3 week, 2:0 weekday
        logic [7:0] date;    // BCD date
        logic [7:0] hour;    // BCD hour, 24-hour
    } dst_rule_t;

    typedef struct packed {
        logic [7:0] month;
        logic [7:0] date;
        logic [2:0] wday;
        logic [7:0] hour;
        logic [7:0] mdays;
    } dst_time_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_FWD   = 2'd2,
        S_REV   = 2'd3
    } dst_state_t;

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] == 4'd9) return {b[7:4] + 4'd1, 4'd0};
        return {b[7:4], b[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_dec(input logic [7:0] b);
        if (b[3:0] == 4'd0) return {b[7:4] - 4'd1, 4'd9};
        return {b[7:4], b[3:0] - 4'd1};
    endfunction

endpackage

// File: rtl/dst_rule_regs.sv
module dst_rule_regs
    import dst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output dst_rule_t         fwd_rule,
    output dst_rule_t         rev_rule,
    output logic              rules_on,
    output logic              disable_wr
);
    localparam int unsigned NUM_REGS = NUM_RULES * NUM_RULE_REGS;

    logic [NUM_REGS-1:0][7:0] regs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_addr == ADDR_W'(BASE_ADDR + i)) regs_q[i] <= wr_data;
            end
        end
    end

    assign fwd_rule   = '{month: regs_q[0], wkday: regs_q[1], date: regs_q[2], hour: regs_q[3]};
    assign rev_rule   = '{month: regs_q[4], wkday: regs_q[5], date: regs_q[6], hour: regs_q[7]};
    assign rules_on   = regs_q[0][7];
    assign disable_wr = wr_en && (wr_addr == ADDR_W'(BASE_ADDR)) && !wr_data[7];

    // R1
    enable_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(BASE_ADDR)) |=> (rules_on == $past(wr_data[7])));

endmodule

// File: rtl/dst_rule_match.sv
module dst_rule_match
    import dst_pkg::*;
(
    input  dst_rule_t rule,
    input  dst_time_t now,
    output logic      hit
);
    logic [7:0] date_bin;
    logic [7:0] mdays_bin;
    logic [2:0] week_no;
    logic       last_ok;
    logic       week_ok;
    logic       day_ok;
    logic       use_week;
    logic       unused_bits;

    assign unused_bits = ^{rule.wkday[7], rule.month[7:5]};
    assign use_week    = rule.wkday[6];

    always_comb begin
        date_bin  = bcd_to_bin(now.date);
        mdays_bin = bcd_to_bin(now.mdays);
        week_no   = 3'd1;
        for (int k = 1; k < int'(MAX_WEEKS); k++) begin
            if (date_bin > 8'(k * int'(DAYS_PER_WEEK))) week_no = 3'(k + 1);
        end
        last_ok = ({1'b0, date_bin} + 9'(DAYS_PER_WEEK)) > {1'b0, mdays_bin};
        week_ok = (rule.wkday[5:3] == LAST_WEEK) ? last_ok : (rule.wkday[5:3] == week_no);
        day_ok  = use_week ? (week_ok && (rule.wkday[2:0] == now.wday))
                           : (rule.date == now.date);
        hit     = ({3'd0, rule.month[4:0]} == now.month) && (rule.hour == now.hour) && day_ok;
    end

endmodule

// File: rtl/dst_ctrl.sv
module dst_ctrl
    import dst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hour_tick,
    input  logic       fwd_hit,
    input  logic       rev_hit,
    input  logic       rules_on,
    input  logic       disable_wr,
    input  logic [7:0] snap_hour,
    output logic       hour_load,
    output logic [7:0] hour_value,
    output logic       dst_flag
);
    dst_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (hour_tick) state_d = S_CHECK;
            S_CHECK: begin
                if (rules_on && !dst_flag && fwd_hit)     state_d = S_FWD;
                else if (rules_on && dst_flag && rev_hit) state_d = S_REV;
                else                                      state_d = S_IDLE;
            end
            S_FWD:   state_d = S_IDLE;
            S_REV:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                dst_flag <= 1'b0;
        else if (disable_wr)       dst_flag <= 1'b0;
        else if (state_q == S_FWD) dst_flag <= 1'b1;
        else if (state_q == S_REV) dst_flag <= 1'b0;
    end

    always_comb begin
        hour_load  = 1'b0;
        hour_value = 8'h00;
        unique case (state_q)
            S_FWD: begin
                hour_load  = 1'b1;
                hour_value = bcd_inc(snap_hour);
            end
            S_REV: begin
                hour_load  = 1'b1;
                hour_value = bcd_dec(snap_hour);
            end
            default: ;
        endcase
    end

    // R7
    load_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hour_load |=> !hour_load);
    // R7
    fwd_needs_clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FWD) |-> !dst_flag);
    // R10
    flag_rise_after_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dst_flag) |-> $past(state_q == S_FWD));
    // R8
    flag_fall_after_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dst_flag) |-> ($past(state_q == S_REV) || $past(disable_wr)));
    // R2
    check_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK) |-> $past(hour_tick));

endmodule

// File: rtl/dst_adjuster.sv
module dst_adjuster
    import dst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              sec_tick,
    input  logic [7:0]        cur_month,
    input  logic [7:0]        cur_date,
    input  logic [2:0]        cur_wday,
    input  logic [7:0]        cur_hour,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_mdays,
    output logic              hour_load,
    output logic [7:0]        hour_value,
    output logic              dst_active
);
    dst_rule_t             fwd_rule, rev_rule;
    dst_rule_t             rules [NUM_RULES];
    logic [NUM_RULES-1:0]  hits;
    logic                  rules_on;
    logic                  disable_wr;
    logic                  hour_tick;
    dst_time_t             snap_q;

    assign hour_tick = sec_tick && (cur_min == 8'h00) && (cur_sec == 8'h00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         snap_q <= '0;
        else if (hour_tick) snap_q <= '{month: cur_month, date: cur_date, wday: cur_wday,
                                        hour: cur_hour, mdays: cur_mdays};
    end

    dst_rule_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fwd_rule   (fwd_rule),
        .rev_rule   (rev_rule),
        .rules_on   (rules_on),
        .disable_wr (disable_wr)
    );

    assign rules[0] = fwd_rule;
    assign rules[1] = rev_rule;

    for (genvar gi = 0; gi < int'(NUM_RULES); gi++) begin : g_match
        dst_rule_match u_match (
            .rule (rules[gi]),
            .now  (snap_q),
            .hit  (hits[gi])
        );
    end

    dst_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hour_tick  (hour_tick),
        .fwd_hit    (hits[0]),
        .rev_hit    (hits[1]),
        .rules_on   (rules_on),
        .disable_wr (disable_wr),
        .snap_hour  (snap_q.hour),
        .hour_load  (hour_load),
        .hour_value (hour_value),
        .dst_flag   (dst_active)
    );

    // R9
    disable_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(BASE_ADDR) && !wr_data[7]) |=> !dst_active);

endmodule

// File: tb/test_dst_adjuster.sv
module test_dst_adjuster;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sec_tick = 1'b0;
    logic [7:0] cur_month = 8'h01, cur_date = 8'h01, cur_hour = 8'h00;
    logic [7:0] cur_min = 8'h00, cur_sec = 8'h00, cur_mdays = 8'h31;
    logic [2:0] cur_wday = 3'd0;
    logic       hour_load, dst_active;
    logic [7:0] hour_value;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dst_adjuster i_dst_adjuster (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sec_tick(sec_tick), .cur_month(cur_month), .cur_date(cur_date), .cur_wday(cur_wday),
        .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec), .cur_mdays(cur_mdays),
        .hour_load(hour_load), .hour_value(hour_value), .dst_active(dst_active)
    );

    typedef struct packed {
        logic [7:0] mon;
        logic [7:0] date;
        logic [2:0] wd;
        logic [7:0] hr;
        logic [7:0] md;
        logic       ld;
        logic [7:0] val;
        logic       fl;
    } vec_t;

    // forward: April, first Sunday, 02h; reverse: October, last Sunday, 02h
    localparam vec_t VECS [8] = '{
        '{8'h04, 8'h01, 3'd3, 8'h02, 8'h30, 1'b0, 8'h00, 1'b0},
        '{8'h04, 8'h05, 3'd0, 8'h01, 8'h30, 1'b0, 8'h00, 1'b0},
        '{8'h04, 8'h05, 3'd0, 8'h02, 8'h30, 1'b1, 8'h03, 1'b1},
        '{8'h04, 8'h12, 3'd0, 8'h02, 8'h30, 1'b0, 8'h00, 1'b1},
        '{8'h10, 8'h18, 3'd0, 8'h02, 8'h31, 1'b0, 8'h00, 1'b1},
        '{8'h10, 8'h25, 3'd0, 8'h02, 8'h31, 1'b1, 8'h01, 1'b0},
        '{8'h10, 8'h25, 3'd0, 8'h02, 8'h31, 1'b0, 8'h00, 1'b0},
        '{8'h04, 8'h05, 3'd0, 8'h02, 8'h30, 1'b1, 8'h03, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hour_event(input logic [7:0] mon, input logic [7:0] date, input logic [2:0] wd,
                              input logic [7:0] hr, input logic [7:0] md, input logic [7:0] mn,
                              input logic ld, input logic [7:0] val, input logic fl,
                              input string req);
        @(negedge clk);
        cur_month = mon; cur_date = date; cur_wday = wd; cur_hour = hr;
        cur_mdays = md; cur_min = mn; cur_sec = 8'h00; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        if (ld) check({req, " R10 early"}, {7'd0, hour_load}, 8'h00);
        @(negedge clk);
        check({req, " load"}, {7'd0, hour_load}, {7'd0, ld});
        if (ld) check({req, " value"}, hour_value, val);
        @(negedge clk);
        check({req, " R10 flag"}, {7'd0, dst_active}, {7'd0, fl});
        if (ld) check({req, " R7 pulse"}, {7'd0, hour_load}, 8'h00);
        cur_min = 8'h01;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset flag", {7'd0, dst_active}, 8'h00);
        check("R7 reset load", {7'd0, hour_load}, 8'h00);
        rst_n = 1'b1;
        // R1 program example rules
        wr(8'h15, 8'h84); wr(8'h16, 8'h48); wr(8'h17, 8'h00); wr(8'h18, 8'h02);
        wr(8'h19, 8'h10); wr(8'h1A, 8'h78); wr(8'h1B, 8'h00); wr(8'h1C, 8'h02);

        // R3 R4 R6 R7 R8 table walk
        for (int i = 0; i < 8; i++) begin
            hour_event(VECS[i].mon, VECS[i].date, VECS[i].wd, VECS[i].hr, VECS[i].md, 8'h00,
                       VECS[i].ld, VECS[i].val, VECS[i].fl, $sformatf("R3 R4 R7 R8 vec%0d", i));
        end

        // R2 tick outside hour boundary
        hour_event(8'h10, 8'h25, 3'd0, 8'h02, 8'h31, 8'h30, 1'b0, 8'h00, 1'b1, "R2 mid-hour");

        // R1 writes outside the window leave enable and flag alone
        wr(8'h14, 8'h00); wr(8'h1D, 8'h00);
        check("R1 stray write", {7'd0, dst_active}, 8'h01);
        hour_event(8'h10, 8'h25, 3'd0, 8'h02, 8'h31, 8'h00, 1'b1, 8'h01, 1'b0, "R1 rules kept");
        hour_event(8'h04, 8'h05, 3'd0, 8'h02, 8'h30, 8'h00, 1'b1, 8'h03, 1'b1, "R7 re-arm");

        // R9 disable write clears flag, R6 disabled rules inert
        wr(8'h15, 8'h04);
        check("R9 disable", {7'd0, dst_active}, 8'h00);
        hour_event(8'h04, 8'h05, 3'd0, 8'h02, 8'h30, 8'h00, 1'b0, 8'h00, 1'b0, "R6 disabled");

        // R4 last week in a 30-day month
        wr(8'h15, 8'h84); wr(8'h19, 8'h11);
        hour_event(8'h04, 8'h05, 3'd0, 8'h02, 8'h30, 8'h00, 1'b1, 8'h03, 1'b1, "R7 fwd");
        hour_event(8'h11, 8'h17, 3'd0, 8'h02, 8'h30, 8'h00, 1'b0, 8'h00, 1'b1, "R4 not last");
        hour_event(8'h11, 8'h24, 3'd0, 8'h02, 8'h30, 8'h00, 1'b1, 8'h01, 1'b0, "R4 last of 30");

        // R5 date mode with BCD carry and borrow
        wr(8'h16, 8'h00); wr(8'h17, 8'h12); wr(8'h18, 8'h09); wr(8'h15, 8'h86);
        hour_event(8'h06, 8'h11, 3'd4, 8'h09, 8'h30, 8'h00, 1'b0, 8'h00, 1'b0, "R5 wrong date");
        hour_event(8'h06, 8'h12, 3'd5, 8'h09, 8'h30, 8'h00, 1'b1, 8'h10, 1'b1, "R5 R7 carry");
        wr(8'h1A, 8'h00); wr(8'h1B, 8'h20); wr(8'h1C, 8'h10); wr(8'h19, 8'h06);
        hour_event(8'h06, 8'h20, 3'd6, 8'h10, 8'h30, 8'h00, 1'b1, 8'h09, 1'b0, "R5 R8 borrow");

        // R3 second week, Wednesday
        wr(8'h16, 8'h53); wr(8'h18, 8'h02); wr(8'h15, 8'h84);
        hour_event(8'h04, 8'h01, 3'd3, 8'h02, 8'h30, 8'h00, 1'b0, 8'h00, 1'b0, "R3 week1");
        hour_event(8'h04, 8'h08, 3'd3, 8'h02, 8'h30, 8'h00, 1'b1, 8'h03, 1'b1, "R3 week2");

        // R9 reset clears the flag
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears", {7'd0, dst_active}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule